// File: doc/BRIEF.md
# GPIO Port Configuration Register Bank

This block is the software-visible control store for one GPIO port. A processor reaches it over a plain single-cycle bus. Writes take effect on the next rising clock edge. Read data is returned combinationally in the same cycle as the request.

The bank holds six bit-per-pin control words:

- pin routing: GPIO versus peripheral
- peripheral choice: primary versus secondary
- output enable
- output level
- interrupt mask
- wake mask

Each of these six words has two companion alias addresses. The set alias forces the bits written as 1 to 1. The clear alias forces them to 0. Bits written as 0 leave the word unchanged. Software can therefore change single pins without a read-modify-write sequence.

The bank also holds:

- two pull-selection words, which together form a 2-bit code per pin;
- two drive-strength words;
- a read-only view of the pin levels;
- an interrupt-clear address, whose written mask is handed to the interrupt logic outside this block.

The stored words drive per-pin control outputs toward the pad ring.

Top module: `gpio_bank`

## Requirements
- R1: After reset every stored word is zero. Every pin is therefore routed to its peripheral (pinGpio=0), uses the primary peripheral function (pinAltSel=0), has its output disabled, drives a low level, is masked for interrupt and wake, has no pull, and has drive bits of zero.
- R2: A write to a base address loads the full word on the next clock edge, and a read of that address returns it. The base addresses are: routing 0x00 (bit 1 = GPIO, 0 = peripheral), output enable 0x0C, output level 0x18, interrupt mask 0x34, wake mask 0x4C, and peripheral choice 0x68 (bit 1 = secondary, 0 = primary).
- R3: A write to a set alias (base+4 for the six words of R2) sets every target bit written as 1 and leaves the other bits unchanged.
- R4: A write to a clear alias (base+8 for the six words of R2) clears every target bit written as 1 and leaves the other bits unchanged.
- R5: Every set and clear alias reads as zero.
- R6: Address 0x24 reads the current pin input levels. Writes to 0x24 change nothing.
- R7: The pull code of pin i has bit 0 in word 0x60 bit i and bit 1 in word 0x64 bit i. Code 1 asserts pinPullUp, code 2 asserts pinPullDn, and codes 0 and 3 assert neither. Both words read back.
- R8: The drive-strength words at 0xB0 and 0xB4 are written and read directly, and appear on pinDrv0 and pinDrv1.
- R9: A write to 0x48 presents the write data on intClrMask during that same cycle. intClrMask is zero in every other cycle, and 0x48 reads zero.
- R10: Reserved and unmapped addresses (including 0x44 and 0x58) read zero, and writes to them change no stored word.
- R11: With busSel low, no access happens: no word changes, and intClrMask stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Read data, valid in the request cycle |
| pinIn | input | NUM_PINS | Pin input levels |
| pinGpio | output | NUM_PINS | 1 = pin under GPIO control |
| pinAltSel | output | NUM_PINS | 1 = secondary peripheral function |
| pinOutEn | output | NUM_PINS | Output driver enable |
| pinOut | output | NUM_PINS | Output level |
| pinIntEn | output | NUM_PINS | Interrupt mask (1 = enabled) |
| pinWakeEn | output | NUM_PINS | Wake mask (1 = enabled) |
| pinPullUp | output | NUM_PINS | Weak pull-up enable |
| pinPullDn | output | NUM_PINS | Weak pull-down enable |
| pinDrv0 | output | NUM_PINS | Drive-strength bit 0 |
| pinDrv1 | output | NUM_PINS | Drive-strength bit 1 |
| intClrMask | output | NUM_PINS | Interrupt-clear mask, one cycle per write to 0x48 |

## Verification
The bench builds the bank with NUM_PINS at 32 and ADDR_W at 8, so every word is a full 32-bit word and the highest pin is covered by each pattern. An 8-bit address covers the whole map, plus unmapped offsets up to 0xFC for the reserved-address checks. With this width, random mixes of direct, set-alias and clear-alias writes to the same word can hit bit 31 next to bit 0. All four pull codes are exercised on neighbouring pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Indices of the stored words
  localparam int NUM_WORDS   = 10;
  localparam int NUM_ALIASED = 6;   // words 0..5 carry set/clear aliases
  localparam int IDX_FUNC    = 0;
  localparam int IDX_OUTEN   = 1;
  localparam int IDX_OUTDAT  = 2;
  localparam int IDX_INTEN   = 3;
  localparam int IDX_WAKE    = 4;
  localparam int IDX_ALT     = 5;
  localparam int IDX_PULL0   = 6;
  localparam int IDX_PULL1   = 7;
  localparam int IDX_DRV0    = 8;
  localparam int IDX_DRV1    = 9;

  localparam logic [7:0] OFF_SET_ALIAS = 8'h04;
  localparam logic [7:0] OFF_CLR_ALIAS = 8'h08;
  localparam logic [7:0] OFF_PIN_IN    = 8'h24;
  localparam logic [7:0] OFF_INT_CLR   = 8'h48;

  // Byte offset of each stored word
  function automatic logic [7:0] wordBase(input int idx);
    case (idx)
      IDX_FUNC:   wordBase = 8'h00;
      IDX_OUTEN:  wordBase = 8'h0C;
      IDX_OUTDAT: wordBase = 8'h18;
      IDX_INTEN:  wordBase = 8'h34;
      IDX_WAKE:   wordBase = 8'h4C;
      IDX_ALT:    wordBase = 8'h68;
      IDX_PULL0:  wordBase = 8'h60;
      IDX_PULL1:  wordBase = 8'h64;
      IDX_DRV0:   wordBase = 8'hB0;
      IDX_DRV1:   wordBase = 8'hB4;
      default:    wordBase = 8'hFF;
    endcase
  endfunction

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] wrDir;
    logic [NUM_WORDS-1:0] wrSet;
    logic [NUM_WORDS-1:0] wrClr;
    logic [NUM_WORDS-1:0] rdWord;
    logic                 rdIn;
    logic                 intClr;
  } strobeT;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            strobe
);

  always_comb begin
    strobe = '0;
    if (busSel) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (busAddr == ADDR_W'(wordBase(i))) begin
          if (busWrite) strobe.wrDir[i]  = 1'b1;
          else          strobe.rdWord[i] = 1'b1;
        end
        if (i < NUM_ALIASED && busWrite) begin
          if (busAddr == ADDR_W'(wordBase(i) + OFF_SET_ALIAS)) strobe.wrSet[i] = 1'b1;
          if (busAddr == ADDR_W'(wordBase(i) + OFF_CLR_ALIAS)) strobe.wrClr[i] = 1'b1;
        end
      end
      if (!busWrite && busAddr == ADDR_W'(OFF_PIN_IN)) strobe.rdIn   = 1'b1;
      if (busWrite  && busAddr == ADDR_W'(OFF_INT_CLR)) strobe.intClr = 1'b1;
    end
  end

  // R11: no access without select
  a_r11_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strobe == '0));

  // R10: one access reaches at most one target
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDir, strobe.wrSet, strobe.wrClr, strobe.rdWord, strobe.rdIn, strobe.intClr}));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobeT                              strobe,
  input  logic [NUM_PINS-1:0]                 busWdata,
  input  logic [NUM_PINS-1:0]                 pinIn,
  output logic [NUM_PINS-1:0]                 busRdata,
  output logic [NUM_PINS-1:0]                 intClrMask,
  output logic [NUM_WORDS-1:0][NUM_PINS-1:0]  words
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                words[g] <= '0;
      else if (strobe.wrDir[g]) words[g] <= busWdata;
      else if (strobe.wrSet[g]) words[g] <= words[g] | busWdata;
      else if (strobe.wrClr[g]) words[g] <= words[g] & ~busWdata;
    end

    // R3: set alias raises written ones, keeps the rest
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrSet[g] |=> (words[g] == ($past(words[g]) | $past(busWdata))));

    // R4: clear alias lowers written ones, keeps the rest
    a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrClr[g] |=> (words[g] == ($past(words[g]) & ~$past(busWdata))));
  end

  always_comb begin
    busRdata = strobe.rdIn ? pinIn : '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (strobe.rdWord[i]) busRdata = busRdata | words[i];
  end

  assign intClrMask = strobe.intClr ? busWdata : '0;

  // R10: without a write strobe no stored word moves
  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrDir == '0 && strobe.wrSet == '0 && strobe.wrClr == '0) |=> $stable(words));

  // R6: input view reads the pins
  a_r6_input_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdIn |-> (busRdata == pinIn));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinGpio,
  output logic [NUM_PINS-1:0] pinAltSel,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinIntEn,
  output logic [NUM_PINS-1:0] pinWakeEn,
  output logic [NUM_PINS-1:0] pinPullUp,
  output logic [NUM_PINS-1:0] pinPullDn,
  output logic [NUM_PINS-1:0] pinDrv0,
  output logic [NUM_PINS-1:0] pinDrv1,
  output logic [NUM_PINS-1:0] intClrMask
);

  strobeT                              strobe;
  logic [NUM_WORDS-1:0][NUM_PINS-1:0]  words;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .pinIn(pinIn), .busRdata(busRdata), .intClrMask(intClrMask), .words(words)
  );

  assign pinGpio   = words[IDX_FUNC];
  assign pinAltSel = words[IDX_ALT];
  assign pinOutEn  = words[IDX_OUTEN];
  assign pinOut    = words[IDX_OUTDAT];
  assign pinIntEn  = words[IDX_INTEN];
  assign pinWakeEn = words[IDX_WAKE];
  assign pinDrv0   = words[IDX_DRV0];
  assign pinDrv1   = words[IDX_DRV1];
  // Two-bit pull code per pin: 1 = up, 2 = down, 0 and 3 = none
  assign pinPullUp = words[IDX_PULL0] & ~words[IDX_PULL1];
  assign pinPullDn = words[IDX_PULL1] & ~words[IDX_PULL0];

  // R1: first cycle out of reset shows every control at rest
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinGpio == '0 && pinOutEn == '0 && pinOut == '0 &&
                     pinIntEn == '0 && pinWakeEn == '0 && pinAltSel == '0 &&
                     pinPullUp == '0 && pinPullDn == '0));

  // R7: a pin never has both pulls
  a_r7_pull_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (pinPullUp & pinPullDn) == '0);

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [NP-1:0] busWdata = '0, pinIn = '0;
  logic [NP-1:0] busRdata, pinGpio, pinAltSel, pinOutEn, pinOut, pinIntEn, pinWakeEn;
  logic [NP-1:0] pinPullUp, pinPullDn, pinDrv0, pinDrv1, intClrMask;

  int tests = 0, fails = 0;
  bit done = 0, modelOn = 0;
  string curReq = "R1";
  logic [NP-1:0] m [10];   // func, outEn, outDat, intEn, wake, alt, pull0, pull1, drv0, drv1

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinGpio(pinGpio),
    .pinAltSel(pinAltSel), .pinOutEn(pinOutEn), .pinOut(pinOut), .pinIntEn(pinIntEn),
    .pinWakeEn(pinWakeEn), .pinPullUp(pinPullUp), .pinPullDn(pinPullDn),
    .pinDrv0(pinDrv0), .pinDrv1(pinDrv1), .intClrMask(intClrMask)
  );

  function automatic logic [7:0] baseOf(int i);
    logic [7:0] tbl [10] = '{8'h00, 8'h0C, 8'h18, 8'h34, 8'h4C, 8'h68, 8'h60, 8'h64, 8'hB0, 8'hB4};
    return tbl[i];
  endfunction

  task automatic chk(string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] modelRead(logic [7:0] a);
    for (int i = 0; i < 10; i++) if (a == baseOf(i)) return m[i];
    if (a == 8'h24) return pinIn;
    return '0;
  endfunction

  function automatic void modelWrite(logic [7:0] a, logic [NP-1:0] d);
    for (int i = 0; i < 10; i++) begin
      if (a == baseOf(i)) m[i] = d;
      if (i < 6 && a == baseOf(i) + 8'd4) m[i] = m[i] | d;
      if (i < 6 && a == baseOf(i) + 8'd8) m[i] = m[i] & ~d;
    end
  endfunction

  // Reference comparison of every control output on every clock
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk(curReq, "pinGpio",   pinGpio,   m[0]);
      chk(curReq, "pinOutEn",  pinOutEn,  m[1]);
      chk(curReq, "pinOut",    pinOut,    m[2]);
      chk(curReq, "pinIntEn",  pinIntEn,  m[3]);
      chk(curReq, "pinWakeEn", pinWakeEn, m[4]);
      chk(curReq, "pinAltSel", pinAltSel, m[5]);
      chk(curReq, "pinPullUp", pinPullUp, m[6] & ~m[7]);
      chk(curReq, "pinPullDn", pinPullDn, m[7] & ~m[6]);
      chk(curReq, "pinDrv0",   pinDrv0,   m[8]);
      chk(curReq, "pinDrv1",   pinDrv1,   m[9]);
    end
  end

  task automatic doWrite(logic [7:0] a, logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    #1 chk(curReq, "intClrMask", intClrMask, (a == 8'h48) ? d : '0);
    @(posedge clk);
    #1 modelWrite(a, d);
    busSel = 0; busWrite = 0;
  endtask

  task automatic doRead(logic [7:0] a);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 chk(curReq, $sformatf("read %h", a), busRdata, modelRead(a));
    chk(curReq, "intClrMask", intClrMask, '0);
    @(posedge clk);
    #1 busSel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 10; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    modelOn = 1;

    // R1: reset state
    curReq = "R1";
    for (int i = 0; i < 10; i++) doRead(baseOf(i));

    // R2: direct writes and read-back
    curReq = "R2";
    for (int i = 0; i < 6; i++) begin
      doWrite(baseOf(i), 32'hA5C3_0F81 ^ (32'h1111_1111 * i));
      doRead(baseOf(i));
    end

    // R3: set aliases
    curReq = "R3";
    for (int i = 0; i < 6; i++) begin
      doWrite(baseOf(i) + 8'd4, 32'h8000_0001 << i);
      doRead(baseOf(i));
    end

    // R4: clear aliases
    curReq = "R4";
    for (int i = 0; i < 6; i++) begin
      doWrite(baseOf(i) + 8'd8, 32'h8000_0081);
      doRead(baseOf(i));
    end

    // R5: aliases read zero
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin
      doRead(baseOf(i) + 8'd4);
      doRead(baseOf(i) + 8'd8);
    end

    // R6: input view, writes ignored
    curReq = "R6";
    pinIn = 32'hDEAD_BEEF; doRead(8'h24);
    pinIn = 32'h0123_4567; doRead(8'h24);
    doWrite(8'h24, 32'hFFFF_FFFF);
    doRead(8'h24);

    // R7: pull codes 0,1,2,3 on pins 0..3
    curReq = "R7";
    doWrite(8'h60, 32'h0000_000A);
    doWrite(8'h64, 32'h0000_000C);
    @(negedge clk);
    chk("R7", "pull-up pin1", pinPullUp, 32'h0000_0002);
    chk("R7", "pull-down pin2", pinPullDn, 32'h0000_0004);
    doRead(8'h60); doRead(8'h64);

    // R8: drive strength
    curReq = "R8";
    doWrite(8'hB0, 32'h00FF_00FF); doWrite(8'hB4, 32'hF0F0_F0F0);
    doRead(8'hB0); doRead(8'hB4);

    // R9: interrupt clear mask
    curReq = "R9";
    doWrite(8'h48, 32'h0000_8421);
    doRead(8'h48);

    // R10: reserved addresses
    curReq = "R10";
    doWrite(8'h44, 32'hFFFF_FFFF); doWrite(8'h58, 32'hFFFF_FFFF); doWrite(8'hFC, 32'hFFFF_FFFF);
    doRead(8'h44); doRead(8'h58); doRead(8'hFC);

    // R11: unselected write does nothing
    curReq = "R11";
    @(negedge clk);
    busSel = 0; busWrite = 1; busAddr = 8'h48; busWdata = 32'hFFFF_FFFF;
    #1 chk("R11", "intClrMask idle", intClrMask, '0);
    busAddr = 8'h00;
    @(posedge clk); #1 busWrite = 0;
    doRead(8'h00);

    // Mixed traffic, R2 R3 R4 together
    curReq = "R2R3R4 mix";
    for (int k = 0; k < 300; k++) begin
      int w = $urandom_range(0, 9);
      int kind = (w < 6) ? $urandom_range(0, 2) : 0;
      logic [7:0] a = baseOf(w) + 8'(kind * 4);
      doWrite(a, $urandom);
      if (k % 4 == 0) doRead(baseOf(w));
    end

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule